// File: doc/BRIEF.md
# NAND Bus ECC Sequence Monitor

This block watches a NAND flash bus without driving it. It sees the command latch and address latch enables, a write strobe and a read strobe, each one clock cycle wide per bus access, and the I/O bus. From these it decides which bus accesses belong to the main data area of a page. Those accesses are passed on to a separate parity engine. A program sequence or a read sequence each clears that engine when it starts. Data is counted only after addressing is complete. The result is frozen once the last main-area word has passed.

In a read sequence, the monitor then treats the next four data reads as the error code that was stored earlier in the spare area. It collects the low byte of each read into a 32-bit word and raises a valid flag so the code can be compared with the computed one. Command and address cycles that come between these four reads are ignored, for example a column jump to the spare area.

The number of address cycles and the page size are set by inputs. The word count per page is a parameter-scaled power-of-two multiple.

Top module: `nbm_seq_monitor`

## Requirements
- R1: A command cycle (write strobe, command latch 1, address latch 0) with low byte 80h gives a one-cycle `ecc_clear` pulse in the next cycle. It starts a program sequence, drops `ecc_locked` and `code_valid`, and zeroes `stored_code`.
- R2: A command cycle with low byte 00h does the same as R1 but starts a read sequence. This holds in any state, including in the middle of another sequence.
- R3: In a program sequence, data writes are ignored until the configured number of address cycles has been seen. The `addr_cycles` value is clamped: 0 to 2 act as 3, and 6 to 7 act as 5.
- R4: In a read sequence, data reads count only after the address cycles are complete and a later 30h command has arrived. A 30h that arrives before the address cycles are complete is ignored.
- R5: Only data cycles, with both latch enables low, can produce `ecc_acc`. In a program sequence only writes count, and in a read sequence only reads count. `ecc_acc` is high for one cycle per counted word, and `ecc_acc_data` carries that word.
- R6: The main area holds `BASE_WORDS << page_sel` words. After the last one, `ecc_locked` rises. From then on no further `ecc_acc` occurs until the next 80h or 00h command.
- R7: After the read main area, the next four data reads are captured in order into `stored_code`, at bits 7:0, 15:8, 23:16 and 31:24, using the low byte of the bus. Command and address cycles in between are ignored. `code_valid` rises after the fourth read.
- R8: After a program main area is locked, command 85h, its column address cycles and further data writes change neither `ecc_locked` nor `ecc_acc`.
- R9: If a new 80h or 00h command arrives before all four code reads, `code_valid` stays low.
- R10: Commands other than 80h, 00h and an in-place 30h neither restart nor clear the sequence.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nand_cle | input | 1 | Command latch enable seen on the bus |
| nand_ale | input | 1 | Address latch enable seen on the bus |
| nand_wr_stb | input | 1 | One-cycle pulse per bus write access |
| nand_rd_stb | input | 1 | One-cycle pulse per bus read access |
| nand_io | input | IO_W | Bus data during the access |
| addr_cycles | input | 3 | Address cycles per sequence (clamped 3..5) |
| page_sel | input | 2 | Main-area size select, words = BASE_WORDS << page_sel |
| ecc_clear | output | 1 | Clear pulse to the parity engine |
| ecc_acc | output | 1 | Accumulate strobe to the parity engine |
| ecc_acc_data | output | IO_W | Word to accumulate |
| ecc_locked | output | 1 | Main area complete, result frozen |
| code_valid | output | 1 | Four stored-code bytes captured |
| stored_code | output | 32 | Captured stored code |

## Verification
A table of complete sequences covers both directions, every page size, and address settings inside and outside the legal range. The out-of-range settings show whether clamping is applied, because one address cycle too few or too many changes the word count. Each sequence mixes in stray data accesses before addressing ends, accesses in the wrong direction and random-read commands between code reads. The exact count and sum of `ecc_acc_data` therefore tell apart a correct gate from one that leaks or drops words. Directed cases cover an early 30h, a random write after lock, foreign commands mid-page and aborted code capture.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_P_ADDR,
      ST_P_DATA,
      ST_P_DONE,
      ST_R_ADDR,
      ST_R_CONF,
      ST_R_DATA,
      ST_R_CODE,
      ST_R_DONE
   } nbm_state_t;

   localparam logic [7:0] OP_PROGRAM   = 8'h80;
   localparam logic [7:0] OP_READ      = 8'h00;
   localparam logic [7:0] OP_READ_CONF = 8'h30;

   localparam int ADDR_MIN = 3;
   localparam int ADDR_MAX = 5;
endpackage

// File: rtl/nbm_cycle_decode.sv
module nbm_cycle_decode
   import nbm_pkg::*;
(
   input  logic       cle,
   input  logic       ale,
   input  logic       wr_stb,
   input  logic       rd_stb,
   input  logic [7:0] op,
   output logic       cmd_prog,
   output logic       cmd_read,
   output logic       cmd_conf,
   output logic       addr_wr,
   output logic       data_wr,
   output logic       data_rd
);
   logic cmd_wr;

   always_comb begin
      cmd_wr   = wr_stb && cle && !ale;
      cmd_prog = cmd_wr && (op == OP_PROGRAM);
      cmd_read = cmd_wr && (op == OP_READ);
      cmd_conf = cmd_wr && (op == OP_READ_CONF);
      addr_wr  = wr_stb && ale && !cle;
      data_wr  = wr_stb && !cle && !ale;
      data_rd  = rd_stb && !cle && !ale;
   end
endmodule

// File: rtl/nbm_step_counter.sv
module nbm_step_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/nbm_code_capture.sv
module nbm_code_capture #(
   parameter int CODE_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    take,
   input  logic [7:0]              din,
   output logic [CODE_BYTES*8-1:0] code,
   output logic                    last_take
);
   localparam int IDX_W = $clog2(CODE_BYTES) + 1;

   logic [IDX_W-1:0] idx;

   nbm_step_counter #(.W(IDX_W)) idx_cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .step  (take),
      .cnt   (idx)
   );

   assign last_take = take && (idx == IDX_W'(CODE_BYTES - 1));

   for (genvar g = 0; g < CODE_BYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            code[g*8 +: 8] <= '0;
         else if (clr)
            code[g*8 +: 8] <= '0;
         else if (take && (idx == IDX_W'(g)))
            code[g*8 +: 8] <= din;
      end
   end
endmodule

// File: rtl/nbm_seq_monitor.sv
module nbm_seq_monitor
   import nbm_pkg::*;
#(
   parameter int IO_W       = 8,
   parameter int BASE_WORDS = 512
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            nand_cle,
   input  logic            nand_ale,
   input  logic            nand_wr_stb,
   input  logic            nand_rd_stb,
   input  logic [IO_W-1:0] nand_io,
   input  logic [2:0]      addr_cycles,
   input  logic [1:0]      page_sel,
   output logic            ecc_clear,
   output logic            ecc_acc,
   output logic [IO_W-1:0] ecc_acc_data,
   output logic            ecc_locked,
   output logic            code_valid,
   output logic [31:0]     stored_code
);
   localparam int CODE_BYTES = 4;
   localparam int MAX_WORDS  = BASE_WORDS * 8;
   localparam int CNT_W      = $clog2(MAX_WORDS) + 1;
   localparam int ADDR_W     = 3;

   if (IO_W != 8 && IO_W != 16) begin : g_bad_width
      $error("nbm_seq_monitor: IO_W must be 8 or 16");
   end
   if (BASE_WORDS < 2) begin : g_bad_base
      $error("nbm_seq_monitor: BASE_WORDS must be at least 2");
   end

   nbm_state_t st_q, st_d;

   logic cmd_prog, cmd_read, cmd_conf, addr_wr, data_wr, data_rd;
   logic start;
   logic [ADDR_W-1:0] addr_cnt, addr_lim;
   logic [CNT_W-1:0]  word_cnt, word_lim;
   logic addr_step, addr_hit, word_step, word_hit, code_step, code_hit;

   nbm_cycle_decode dec_i (
      .cle      (nand_cle),
      .ale      (nand_ale),
      .wr_stb   (nand_wr_stb),
      .rd_stb   (nand_rd_stb),
      .op       (nand_io[7:0]),
      .cmd_prog (cmd_prog),
      .cmd_read (cmd_read),
      .cmd_conf (cmd_conf),
      .addr_wr  (addr_wr),
      .data_wr  (data_wr),
      .data_rd  (data_rd)
   );

   assign start = cmd_prog || cmd_read;

   always_comb begin
      if (addr_cycles < 3'(ADDR_MIN))      addr_lim = 3'(ADDR_MIN);
      else if (addr_cycles > 3'(ADDR_MAX)) addr_lim = 3'(ADDR_MAX);
      else                                 addr_lim = addr_cycles;
   end

   assign word_lim  = CNT_W'(BASE_WORDS) << page_sel;

   assign addr_step = addr_wr && ((st_q == ST_P_ADDR) || (st_q == ST_R_ADDR));
   assign addr_hit  = addr_step && (addr_cnt == addr_lim - 1'b1);
   assign word_step = ((st_q == ST_P_DATA) && data_wr) ||
                      ((st_q == ST_R_DATA) && data_rd);
   assign word_hit  = word_step && (word_cnt == word_lim - 1'b1);
   assign code_step = (st_q == ST_R_CODE) && data_rd;

   nbm_step_counter #(.W(ADDR_W)) addr_cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .step  (addr_step),
      .cnt   (addr_cnt)
   );

   nbm_step_counter #(.W(CNT_W)) word_cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .step  (word_step),
      .cnt   (word_cnt)
   );

   nbm_code_capture #(.CODE_BYTES(CODE_BYTES)) cap_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start),
      .take      (code_step),
      .din       (nand_io[7:0]),
      .code      (stored_code),
      .last_take (code_hit)
   );

   always_comb begin
      st_d = st_q;
      if (cmd_prog)      st_d = ST_P_ADDR;
      else if (cmd_read) st_d = ST_R_ADDR;
      else begin
         unique case (st_q)
            ST_P_ADDR: if (addr_hit) st_d = ST_P_DATA;
            ST_P_DATA: if (word_hit) st_d = ST_P_DONE;
            ST_R_ADDR: if (addr_hit) st_d = ST_R_CONF;
            ST_R_CONF: if (cmd_conf) st_d = ST_R_DATA;
            ST_R_DATA: if (word_hit) st_d = ST_R_CODE;
            ST_R_CODE: if (code_hit) st_d = ST_R_DONE;
            default:   st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         ecc_clear    <= 1'b0;
         ecc_acc      <= 1'b0;
         ecc_acc_data <= '0;
         ecc_locked   <= 1'b0;
         code_valid   <= 1'b0;
      end else begin
         st_q      <= st_d;
         ecc_clear <= start;
         ecc_acc   <= word_step;
         if (word_step) ecc_acc_data <= nand_io;
         if (start) begin
            ecc_locked <= 1'b0;
            code_valid <= 1'b0;
         end else begin
            if (word_hit) ecc_locked <= 1'b1;
            if (code_hit) code_valid <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/nbm_seq_monitor_chk.sv
module nbm_seq_monitor_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        nand_cle,
   input logic        nand_ale,
   input logic        nand_wr_stb,
   input logic        nand_rd_stb,
   input logic [7:0]  nand_op,
   input logic        ecc_clear,
   input logic        ecc_acc,
   input logic        ecc_locked,
   input logic        code_valid,
   input logic [31:0] stored_code
);
   logic is_cmd, go_prog, go_read, go_any;
   assign is_cmd  = nand_wr_stb && nand_cle && !nand_ale;
   assign go_prog = is_cmd && (nand_op == 8'h80);
   assign go_read = is_cmd && (nand_op == 8'h00);
   assign go_any  = go_prog || go_read;

   a_r1_program_start: assert property (@(posedge clk) disable iff (!rst_n)
      go_prog |=> (ecc_clear && !ecc_locked && !code_valid && stored_code == 32'h0));

   a_r2_read_start: assert property (@(posedge clk) disable iff (!rst_n)
      go_read |=> (ecc_clear && !ecc_locked && !code_valid && stored_code == 32'h0));

   a_r1_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_clear && !go_any) |=> !ecc_clear);

   a_r5_only_data: assert property (@(posedge clk) disable iff (!rst_n)
      (nand_cle || nand_ale || !(nand_wr_stb || nand_rd_stb)) |=> !ecc_acc);

   a_r5_controls_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ecc_clear, ecc_acc}));

   a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_locked && !go_any) |=> ecc_locked);

   a_r6_no_acc_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_locked && !go_any) |=> !ecc_acc);

   a_r7_code_held: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && !go_any) |=> (code_valid && $stable(stored_code)));

   a_r7_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid |-> ecc_locked);
endmodule

bind nbm_seq_monitor nbm_seq_monitor_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .nand_cle    (nand_cle),
   .nand_ale    (nand_ale),
   .nand_wr_stb (nand_wr_stb),
   .nand_rd_stb (nand_rd_stb),
   .nand_op     (nand_io[7:0]),
   .ecc_clear   (ecc_clear),
   .ecc_acc     (ecc_acc),
   .ecc_locked  (ecc_locked),
   .code_valid  (code_valid),
   .stored_code (stored_code)
);

// File: tb/nbm_seq_monitor_tb_top.sv
`timescale 1ns/1ps
module nbm_seq_monitor_tb_top;
   localparam int IO_W = 8;
   localparam int BASE = 4;

   // row: {is_read, addr_cycles, page_sel, code}
   localparam logic [37:0] VEC [0:5] = '{
      {1'b0, 3'd3, 2'd0, 32'h0000_0000},
      {1'b1, 3'd4, 2'd1, 32'hA1B2_C3D4},
      {1'b0, 3'd5, 2'd2, 32'h0000_0000},
      {1'b1, 3'd2, 2'd0, 32'h0F1E_2D3C},
      {1'b1, 3'd7, 2'd3, 32'h55AA_00FF},
      {1'b0, 3'd0, 2'd3, 32'h0000_0000}
   };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            cle = 0, ale = 0, wr = 0, rd = 0;
   logic [IO_W-1:0] io = '0;
   logic [2:0]      acfg = 3'd3;
   logic [1:0]      psel = 2'd0;
   logic            ecc_clear, ecc_acc, ecc_locked, code_valid;
   logic [IO_W-1:0] ecc_acc_data;
   logic [31:0]     stored_code;

   nbm_seq_monitor #(.IO_W(IO_W), .BASE_WORDS(BASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .nand_cle(cle), .nand_ale(ale),
      .nand_wr_stb(wr), .nand_rd_stb(rd), .nand_io(io),
      .addr_cycles(acfg), .page_sel(psel),
      .ecc_clear(ecc_clear), .ecc_acc(ecc_acc), .ecc_acc_data(ecc_acc_data),
      .ecc_locked(ecc_locked), .code_valid(code_valid), .stored_code(stored_code)
   );

   int checks = 0, fails = 0;
   int acc_cnt = 0, clr_cnt = 0;
   longint acc_sum = 0;
   bit finished = 0;

   always @(negedge clk) if (rst_n) begin
      if (ecc_acc) begin acc_cnt++; acc_sum += ecc_acc_data; end
      if (ecc_clear) clr_cnt++;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic c, a, w, r, input logic [7:0] d);
      cle = c; ale = a; wr = w; rd = r; io = IO_W'(d);
      @(posedge clk); #1;
      cle = 0; ale = 0; wr = 0; rd = 0;
   endtask
   task automatic cmd(input logic [7:0] op); bus(1, 0, 1, 0, op); endtask
   task automatic adr();                     bus(0, 1, 1, 0, 8'h00); endtask
   task automatic dwr(input logic [7:0] d);  bus(0, 0, 1, 0, d); endtask
   task automatic drd(input logic [7:0] d);  bus(0, 0, 0, 1, d); endtask
   task automatic idle();                    @(posedge clk); #1; endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int a0, c0, words, eff;
      longint s0;
      logic       isr;
      logic [31:0] code;

      repeat (3) @(posedge clk);
      #1;
      chk(!ecc_clear && !ecc_acc && !ecc_locked && !code_valid && stored_code == 0,
          "R11 outputs in reset", {ecc_clear, ecc_acc, ecc_locked, code_valid}, 0);
      rst_n = 1'b1;
      idle();
      chk(!ecc_clear && !ecc_acc && !ecc_locked && !code_valid,
          "R11 outputs after reset", {ecc_clear, ecc_acc, ecc_locked, code_valid}, 0);

      // table of full sequences
      for (int k = 0; k < 6; k++) begin
         {isr, acfg, psel, code} = VEC[k];
         eff   = (acfg < 3) ? 3 : (acfg > 5) ? 5 : int'(acfg);
         words = BASE << psel;
         a0 = acc_cnt; s0 = acc_sum;
         cmd(isr ? 8'h00 : 8'h80);
         chk(ecc_clear == 1'b1, isr ? "R2 clear pulse" : "R1 clear pulse", ecc_clear, 1);
         if (isr) drd(8'h33); else dwr(8'h33);
         for (int i = 0; i < eff - 1; i++) adr();
         if (isr) drd(8'h33); else dwr(8'h33);
         adr();
         if (isr) begin drd(8'h44); cmd(8'h30); end
         for (int i = 0; i < words; i++) begin
            if (isr) drd(8'(i + 1)); else dwr(8'(i + 1));
            if (i == 1) begin if (isr) dwr(8'h77); else drd(8'h77); end
         end
         idle();
         chk(acc_cnt - a0 == words, isr ? "R4 word count" : "R3 word count", acc_cnt - a0, words);
         chk(acc_sum - s0 == longint'(words * (words + 1) / 2), "R5 word data sum",
             acc_sum - s0, words * (words + 1) / 2);
         chk(ecc_locked == 1'b1, "R6 locked after last word", ecc_locked, 1);
         if (isr) begin
            chk(code_valid == 1'b0, "R7 not valid before code", code_valid, 0);
            drd(code[7:0]);
            cmd(8'h05); adr(); adr(); cmd(8'hE0);
            drd(code[15:8]); drd(code[23:16]);
            chk(code_valid == 1'b0, "R7 not valid after three", code_valid, 0);
            drd(code[31:24]);
            chk(code_valid == 1'b1, "R7 valid after four", code_valid, 1);
            chk(stored_code == code, "R7 stored code", stored_code, code);
            idle();
            chk(acc_cnt - a0 == words, "R6 no acc on code reads", acc_cnt - a0, words);
         end else begin
            dwr(8'h99); idle();
            chk(acc_cnt - a0 == words, "R6 no acc after lock", acc_cnt - a0, words);
            chk(code_valid == 1'b0 && stored_code == 0, "R7 no code in program",
                stored_code, 0);
         end
      end

      acfg = 3'd3; psel = 2'd0;

      // R1: clear pulse lasts one cycle
      cmd(8'h80);
      chk(ecc_clear == 1'b1, "R1 clear high", ecc_clear, 1);
      idle();
      chk(ecc_clear == 1'b0, "R1 clear one cycle", ecc_clear, 0);

      // R8: random write after lock
      adr(); adr(); adr();
      for (int i = 0; i < BASE; i++) dwr(8'h10);
      idle();
      a0 = acc_cnt; c0 = clr_cnt;
      cmd(8'h85); adr(); adr(); dwr(8'h01); dwr(8'h02); cmd(8'h10);
      idle();
      chk(ecc_locked == 1'b1, "R8 lock kept after random write", ecc_locked, 1);
      chk(acc_cnt == a0, "R8 no acc from random write", acc_cnt - a0, 0);
      chk(clr_cnt == c0, "R10 no clear from 85h/10h", clr_cnt - c0, 0);

      // R4: early 30h ignored
      a0 = acc_cnt;
      cmd(8'h00); adr(); cmd(8'h30); adr(); adr();
      drd(8'h01); drd(8'h02); idle();
      chk(acc_cnt == a0, "R4 early confirm ignored", acc_cnt - a0, 0);
      cmd(8'h30);
      for (int i = 0; i < BASE; i++) drd(8'h05);
      idle();
      chk(acc_cnt - a0 == BASE && ecc_locked, "R4 counts after late confirm", acc_cnt - a0, BASE);

      // R10: foreign commands mid-page do not restart
      a0 = acc_cnt; c0 = clr_cnt;
      cmd(8'h00); adr(); adr(); adr(); cmd(8'h30);
      drd(8'h01); drd(8'h01); cmd(8'h10); cmd(8'h05); drd(8'h01); drd(8'h01);
      idle();
      chk(acc_cnt - a0 == BASE, "R10 count unbroken", acc_cnt - a0, BASE);
      chk(ecc_locked == 1'b1 && clr_cnt - c0 == 1, "R10 one clear only", clr_cnt - c0, 1);

      // R9: abort during code capture
      drd(8'hAA); drd(8'hBB);
      cmd(8'h00);
      chk(code_valid == 1'b0 && stored_code == 0, "R9 abort by read", stored_code, 0);
      adr(); adr(); adr(); cmd(8'h30);
      for (int i = 0; i < BASE; i++) drd(8'h01);
      drd(8'h11); drd(8'h22); drd(8'h33);
      cmd(8'h80);
      chk(code_valid == 1'b0 && ecc_locked == 1'b0, "R9 abort by program",
          {code_valid, ecc_locked}, 0);
      drd(8'h44); idle();
      chk(code_valid == 1'b0, "R9 stays low", code_valid, 0);

      // R2: read start mid-program
      adr(); adr(); adr(); dwr(8'h01);
      cmd(8'h00);
      chk(ecc_clear == 1'b1 && !ecc_locked, "R2 restart mid-program", ecc_clear, 1);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule